// File: doc/BRIEF.md
# Segment Descriptor Cache Access Checker

This block keeps the hidden descriptor state of one memory segment and validates every memory reference made through that segment. The cache holds a 32-bit base, a 32-bit limit and a decoded access-rights word. It is written through a load port. That port takes either an ordinary descriptor load, which applies granularity scaling and refuses a segment marked absent, or a direct state load, which stores what it is given as is.

Each request carries an offset, an access kind and the current privilege level. One cycle later the block returns the linear address (base plus offset, wrapping at 2^32), a valid strobe and a fault indication with its vector. A parameter marks whether the instance serves the code segment. Only that slot reports the default operand size, and only that slot honours the rule that a writable data descriptor loaded into the code segment may also be executed.

Top module: `seg_cache_chk`

## Requirements
- R1: After reset the cache is marked not present and `rsp_valid`, `ld_done` and `cs_op32` are 0. A request issued right after reset faults with vector 13.
- R2: Rights word fields: present bit 23, privilege level bits 22:21, code/data flag bit 20 (1 = code or data, 0 = system), type bits 19:17 (executable, expand-down or conforming, writable or readable), granularity bit 14, size bit 13. An ordinary load with granularity 1 stores the limit as `{raw[19:0], 12'hFFF}`. With granularity 0 it stores the raw limit.
- R3: A direct load stores the limit exactly as supplied, whatever the granularity bit is.
- R4: `ld_done` pulses one cycle after `ld_valid`. An ordinary load with present = 0 is refused: `ld_vec` is 11 and the cache keeps its previous contents. Any accepted load gives `ld_vec` = 0.
- R5: A direct load with present = 0 is accepted (`ld_vec` = 0), and every later request through the cache faults with vector 13.
- R6: A request at edge N gives `rsp_valid` = 1 after edge N, with `rsp_lin` = base + offset mod 2^32 (reported even when the request faults). `rsp_vec` is 13 when `rsp_fault` = 1 and 0 otherwise. `rsp_valid` is 0 after any edge without a request.
- R7: For expand-up segments, and for all code segments, an offset greater than the limit faults.
- R8: For an expand-down data segment, an offset less than or equal to the limit faults. When the size bit is 0, an offset above 0xFFFF also faults.
- R9: Access kinds are 0 = read, 1 = write, 2 = execute. A write to a code segment or to read-only data faults. A read from execute-only code faults. An execute request on data faults, except as R10 allows.
- R10: In the code-segment slot (`CS_SLOT` = 1), an execute request on writable data rights does not fault. In any other slot the same request faults.
- R11: `cs_op32` equals the cached size bit in the code-segment slot and is always 0 in other slots.
- R12: For every segment except conforming code, a request whose privilege level is numerically greater than the cached privilege level faults. Conforming code ignores the privilege level.
- R13: Rights with the code/data flag at 0 (system) fault on any request. Access kind 3 always faults.
- R14: When a load and a request fall in the same cycle, the request is judged against the cache contents from before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe |
| ld_direct | input | 1 | 1 = direct state load, 0 = ordinary descriptor load |
| ld_base | input | AW | Base address to load |
| ld_limit | input | AW | Raw limit to load |
| ld_rights | input | 32 | Access-rights word to load |
| rq_valid | input | 1 | Request strobe |
| rq_offset | input | AW | Offset within the segment |
| rq_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| rq_cpl | input | 2 | Current privilege level |
| ld_done | output | 1 | Load completed, one cycle after the strobe |
| ld_vec | output | 8 | 11 if the load was refused, else 0 |
| rsp_valid | output | 1 | Response strobe |
| rsp_lin | output | AW | Linear address |
| rsp_fault | output | 1 | Request faulted |
| rsp_vec | output | 8 | 13 on fault, else 0 |
| cs_op32 | output | 1 | 32-bit default size (code-segment slot only) |

## Verification
A cache load and a reference check can land on the same clock edge, and the design must then judge the reference against the contents from before the load. The bench provokes this by first loading a limit of 0xFFF. It then drives a direct load of limit 0 together with a request at offset 0x10. That request must pass, and the next request at the same offset must fault. The same hazard occurs after a refused ordinary load: a request that fits only the earlier limit must still pass, which shows the refused load left the cache untouched.

// File: rtl/seg_cache_pkg.sv
package seg_cache_pkg;
    localparam int RIGHTS_W   = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int SMALL_W    = 16;
    localparam int VEC_W      = 8;

    // rights word field positions
    localparam int P_BIT  = 23;
    localparam int PL_HI  = 22;
    localparam int PL_LO  = 21;
    localparam int S_BIT  = 20;
    localparam int X_BIT  = 19;
    localparam int EC_BIT = 18;
    localparam int WR_BIT = 17;
    localparam int G_BIT  = 14;
    localparam int D_BIT  = 13;

    localparam logic [VEC_W-1:0] VEC_NONE    = 8'd0;
    localparam logic [VEC_W-1:0] VEC_ABSENT  = 8'd11;
    localparam logic [VEC_W-1:0] VEC_PROTECT = 8'd13;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       codedata;
        logic       exe;
        logic       dir_conf;
        logic       wr_rd;
        logic       big;
    } seg_rights_t;

    function automatic seg_rights_t decode_rights(input logic [PL_HI:PL_LO] pl,
                                                  input logic p, input logic s,
                                                  input logic x, input logic ec,
                                                  input logic wr, input logic d);
        seg_rights_t r;
        r.present  = p;
        r.dpl      = pl;
        r.codedata = s;
        r.exe      = x;
        r.dir_conf = ec;
        r.wr_rd    = wr;
        r.big      = d;
        return r;
    endfunction
endpackage

// File: rtl/seg_cache_store.sv
module seg_cache_store
    import seg_cache_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic              ld_direct,
    input  logic [AW-1:0]     ld_base,
    input  logic [AW-1:0]     ld_limit,
    input  seg_rights_t       ld_dec,
    input  logic              ld_gran,
    output logic [AW-1:0]     base_q,
    output logic [AW-1:0]     limit_q,
    output seg_rights_t       rights_q,
    output logic              ld_done,
    output logic [VEC_W-1:0]  ld_vec
);
    logic          refuse;
    logic [AW-1:0] eff_limit;

    always_comb begin
        refuse = !ld_direct && !ld_dec.present;
        if (!ld_direct && ld_gran)
            eff_limit = {ld_limit[AW-PAGE_SHIFT-1:0], {PAGE_SHIFT{1'b1}}};
        else
            eff_limit = ld_limit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            limit_q  <= '0;
            rights_q <= '0;
            ld_done  <= 1'b0;
            ld_vec   <= VEC_NONE;
        end else begin
            ld_done <= ld_valid;
            ld_vec  <= (ld_valid && refuse) ? VEC_ABSENT : VEC_NONE;
            if (ld_valid && !refuse) begin
                base_q   <= ld_base;
                limit_q  <= eff_limit;
                rights_q <= ld_dec;
            end
        end
    end
endmodule

// File: rtl/seg_access_eval.sv
module seg_access_eval
    import seg_cache_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CS_SLOT = 1
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  seg_rights_t   rights,
    input  logic [AW-1:0] offset,
    input  logic [1:0]    kind,
    input  logic [1:0]    cpl,
    output logic [AW-1:0] lin,
    output logic          fault
);
    logic exp_down, limit_bad, type_bad, priv_bad, code_as_data, conforming;

    always_comb begin
        lin          = base + offset;
        exp_down     = !rights.exe && rights.dir_conf;
        conforming   = rights.exe && rights.dir_conf;
        code_as_data = (CS_SLOT != 0) && !rights.exe && rights.wr_rd;

        if (exp_down)
            limit_bad = (offset <= limit) || (!rights.big && (|offset[AW-1:SMALL_W]));
        else
            limit_bad = offset > limit;

        case (acc_kind_e'(kind))
            ACC_READ:  type_bad = rights.exe && !rights.wr_rd;
            ACC_WRITE: type_bad = rights.exe || !rights.wr_rd;
            ACC_EXEC:  type_bad = !rights.exe && !code_as_data;
            default:   type_bad = 1'b1;
        endcase

        priv_bad = !conforming && (cpl > rights.dpl);
        fault    = !rights.present || !rights.codedata || limit_bad || type_bad || priv_bad;
    end
endmodule

// File: rtl/seg_cache_chk.sv
module seg_cache_chk
    import seg_cache_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CS_SLOT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic              ld_direct,
    input  logic [AW-1:0]     ld_base,
    input  logic [AW-1:0]     ld_limit,
    input  logic [31:0]       ld_rights,
    input  logic              rq_valid,
    input  logic [AW-1:0]     rq_offset,
    input  logic [1:0]        rq_kind,
    input  logic [1:0]        rq_cpl,
    output logic              ld_done,
    output logic [VEC_W-1:0]  ld_vec,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_lin,
    output logic              rsp_fault,
    output logic [VEC_W-1:0]  rsp_vec,
    output logic              cs_op32
);
    seg_rights_t   ld_dec, cache_rights;
    logic [AW-1:0] cache_base, cache_limit, chk_lin;
    logic          chk_fault;
    logic          unused_rights_bits;

    assign ld_dec = decode_rights(ld_rights[PL_HI:PL_LO], ld_rights[P_BIT], ld_rights[S_BIT],
                                  ld_rights[X_BIT], ld_rights[EC_BIT], ld_rights[WR_BIT],
                                  ld_rights[D_BIT]);
    assign unused_rights_bits = ^{ld_rights[31:24], ld_rights[16:15], ld_rights[12:0]};

    seg_cache_store #(.AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_direct(ld_direct),
        .ld_base  (ld_base),
        .ld_limit (ld_limit),
        .ld_dec   (ld_dec),
        .ld_gran  (ld_rights[G_BIT]),
        .base_q   (cache_base),
        .limit_q  (cache_limit),
        .rights_q (cache_rights),
        .ld_done  (ld_done),
        .ld_vec   (ld_vec)
    );

    seg_access_eval #(.AW(AW), .CS_SLOT(CS_SLOT)) u_eval (
        .base  (cache_base),
        .limit (cache_limit),
        .rights(cache_rights),
        .offset(rq_offset),
        .kind  (rq_kind),
        .cpl   (rq_cpl),
        .lin   (chk_lin),
        .fault (chk_fault)
    );

    generate
        if (CS_SLOT != 0) begin : g_cs
            assign cs_op32 = cache_rights.big;
        end else begin : g_other
            assign cs_op32 = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_lin   <= '0;
            rsp_fault <= 1'b0;
            rsp_vec   <= VEC_NONE;
        end else begin
            rsp_valid <= rq_valid;
            rsp_lin   <= chk_lin;
            rsp_fault <= rq_valid && chk_fault;
            rsp_vec   <= (rq_valid && chk_fault) ? VEC_PROTECT : VEC_NONE;
        end
    end
endmodule

// File: rtl/seg_cache_chk_sva.sv
module seg_cache_chk_sva #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ld_valid,
    input logic          ld_direct,
    input logic [AW-1:0] ld_limit,
    input logic [31:0]   ld_rights,
    input logic          rq_valid,
    input logic          ld_done,
    input logic [7:0]    ld_vec,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic [7:0]    rsp_vec,
    input logic [AW-1:0] limit_q,
    input logic          present_q
);
    AST_LOAD_ACK: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> ld_done); // R4
    AST_ABSENT_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_direct && !ld_rights[23]) |=> (ld_vec == 8'd11 && $stable(limit_q))); // R4
    AST_DIRECT_RAW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_direct) |=> (limit_q == $past(ld_limit))); // R3
    AST_GRAN_FILL: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_direct && ld_rights[23] && ld_rights[14]) |=> (limit_q[11:0] == 12'hFFF)); // R2
    AST_ABSENT_USE: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && !present_q) |=> rsp_fault); // R5
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rq_valid |=> rsp_valid); // R6
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rq_valid |=> !rsp_valid); // R6
    AST_VEC_CODE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault ? (rsp_vec == 8'd13) : (rsp_vec == 8'd0))); // R6
endmodule

bind seg_cache_chk seg_cache_chk_sva #(.AW(AW)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_direct(ld_direct),
    .ld_limit (ld_limit),
    .ld_rights(ld_rights),
    .rq_valid (rq_valid),
    .ld_done  (ld_done),
    .ld_vec   (ld_vec),
    .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault),
    .rsp_vec  (rsp_vec),
    .limit_q  (cache_limit),
    .present_q(cache_rights.present)
);

// File: tb/seg_cache_chk_tb_top.sv
module seg_cache_chk_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    typedef struct packed {
        int          rq;
        logic        direct;
        logic [31:0] base;
        logic [31:0] limit;
        logic [31:0] rights;
        logic [31:0] offset;
        logic [1:0]  kind;
        logic [1:0]  cpl;
        logic        fault;
        logic [31:0] lin;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{7,  1'b1, 32'h1000, 32'hFFF, 32'h920000, 32'hFFF,   2'd0, 2'd0, 1'b0, 32'h1FFF},  // R7 at limit
        '{7,  1'b1, 32'h1000, 32'hFFF, 32'h920000, 32'h1000,  2'd0, 2'd0, 1'b1, 32'h2000},  // R7 past limit
        '{2,  1'b0, 32'h1000, 32'h2,   32'h924000, 32'h2FFF,  2'd1, 2'd0, 1'b0, 32'h3FFF},  // R2 scaled
        '{2,  1'b0, 32'h1000, 32'h2,   32'h924000, 32'h3000,  2'd1, 2'd0, 1'b1, 32'h4000},  // R2 scaled edge
        '{3,  1'b1, 32'h1000, 32'h2,   32'h924000, 32'h3,     2'd0, 2'd0, 1'b1, 32'h1003},  // R3 raw
        '{8,  1'b1, 32'h0,    32'hFFF, 32'h960000, 32'h1000,  2'd0, 2'd0, 1'b0, 32'h1000},  // R8 above
        '{8,  1'b1, 32'h0,    32'hFFF, 32'h960000, 32'hFFF,   2'd0, 2'd0, 1'b1, 32'hFFF},   // R8 equal
        '{8,  1'b1, 32'h0,    32'hFFF, 32'h960000, 32'h10000, 2'd0, 2'd0, 1'b1, 32'h10000}, // R8 16-bit top
        '{8,  1'b1, 32'h0,    32'hFFF, 32'h962000, 32'h10000, 2'd0, 2'd0, 1'b0, 32'h10000}, // R8 32-bit
        '{9,  1'b1, 32'h0,    32'hFFFF,32'h900000, 32'h0,     2'd1, 2'd0, 1'b1, 32'h0},     // R9 write RO
        '{9,  1'b1, 32'h0,    32'hFFFF,32'h980000, 32'h0,     2'd0, 2'd0, 1'b1, 32'h0},     // R9 read XO
        '{9,  1'b1, 32'h0,    32'hFFFF,32'h900000, 32'h0,     2'd2, 2'd0, 1'b1, 32'h0},     // R9 exec data
        '{10, 1'b1, 32'h0,    32'hFFFF,32'h920000, 32'h0,     2'd2, 2'd0, 1'b0, 32'h0},     // R10 code as data
        '{9,  1'b1, 32'h0,    32'hFFFF,32'h9A0000, 32'h4,     2'd1, 2'd0, 1'b1, 32'h4},     // R9 write code
        '{9,  1'b1, 32'h0,    32'hFFFF,32'h9A0000, 32'h4,     2'd0, 2'd0, 1'b0, 32'h4},     // R9 read code
        '{12, 1'b1, 32'h0,    32'hFFFF,32'h920000, 32'h8,     2'd0, 2'd3, 1'b1, 32'h8},     // R12 low priv
        '{12, 1'b1, 32'h0,    32'hFFFF,32'h9E0000, 32'h8,     2'd2, 2'd3, 1'b0, 32'h8},     // R12 conforming
        '{13, 1'b1, 32'h0,    32'hFFFF,32'h820000, 32'h8,     2'd0, 2'd0, 1'b1, 32'h8},     // R13 system
        '{13, 1'b1, 32'h0,    32'hFFFF,32'h920000, 32'h8,     2'd3, 2'd0, 1'b1, 32'h8},     // R13 kind 3
        '{6,  1'b1, 32'hFFFFF000, 32'hFFFFFFFF, 32'h920000, 32'h2000, 2'd0, 2'd0, 1'b0, 32'h1000} // R6 wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0, ld_direct = 1'b0;
    logic [31:0] ld_base = '0, ld_limit = '0, ld_rights = '0;
    logic        rq_valid = 1'b0;
    logic [31:0] rq_offset = '0;
    logic [1:0]  rq_kind = '0, rq_cpl = '0;

    logic        ld_done, rsp_valid, rsp_fault, cs_op32;
    logic [7:0]  ld_vec, rsp_vec;
    logic [31:0] rsp_lin;
    logic        ds_ld_done, ds_rsp_valid, ds_rsp_fault, ds_op32;
    logic [7:0]  ds_ld_vec, ds_rsp_vec;
    logic [31:0] ds_rsp_lin;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_cache_chk #(.AW(32), .CS_SLOT(1)) dut_i (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_direct(ld_direct),
        .ld_base(ld_base), .ld_limit(ld_limit), .ld_rights(ld_rights),
        .rq_valid(rq_valid), .rq_offset(rq_offset), .rq_kind(rq_kind), .rq_cpl(rq_cpl),
        .ld_done(ld_done), .ld_vec(ld_vec), .rsp_valid(rsp_valid), .rsp_lin(rsp_lin),
        .rsp_fault(rsp_fault), .rsp_vec(rsp_vec), .cs_op32(cs_op32)
    );

    seg_cache_chk #(.AW(32), .CS_SLOT(0)) dut_ds (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_direct(ld_direct),
        .ld_base(ld_base), .ld_limit(ld_limit), .ld_rights(ld_rights),
        .rq_valid(rq_valid), .rq_offset(rq_offset), .rq_kind(rq_kind), .rq_cpl(rq_cpl),
        .ld_done(ds_ld_done), .ld_vec(ds_ld_vec), .rsp_valid(ds_rsp_valid), .rsp_lin(ds_rsp_lin),
        .rsp_fault(ds_rsp_fault), .rsp_vec(ds_rsp_vec), .cs_op32(ds_op32)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, returns at the falling edge after the capture
    task automatic do_load(input logic direct, input logic [31:0] b, input logic [31:0] l, input logic [31:0] r);
        ld_valid = 1'b1; ld_direct = direct; ld_base = b; ld_limit = l; ld_rights = r;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] off, input logic [1:0] k, input logic [1:0] c);
        rq_valid = 1'b1; rq_offset = off; rq_kind = k; rq_cpl = c;
        @(negedge clk);
        rq_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check(ld_done == 1'b0, "R1 ld_done after reset", {31'd0, ld_done}, 32'd0);
        check(cs_op32 == 1'b0, "R1 cs_op32 after reset", {31'd0, cs_op32}, 32'd0);
        do_req(32'h0, 2'd0, 2'd0);
        check(rsp_fault == 1'b1 && rsp_vec == 8'd13, "R1 request on empty cache",
              {24'd0, rsp_vec}, 32'd13);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].direct, VECS[i].base, VECS[i].limit, VECS[i].rights);
            check(ld_done == 1'b1 && ld_vec == 8'd0, $sformatf("R4 load accepted vec %0d", i),
                  {24'd0, ld_vec}, 32'd0);
            do_req(VECS[i].offset, VECS[i].kind, VECS[i].cpl);
            check(rsp_valid == 1'b1, $sformatf("R6 valid vec %0d", i), {31'd0, rsp_valid}, 32'd1);
            check(rsp_fault == VECS[i].fault, $sformatf("R%0d fault vec %0d", VECS[i].rq, i),
                  {31'd0, rsp_fault}, {31'd0, VECS[i].fault});
            check(rsp_vec == (VECS[i].fault ? 8'd13 : 8'd0), $sformatf("R6 vector vec %0d", i),
                  {24'd0, rsp_vec}, VECS[i].fault ? 32'd13 : 32'd0);
            check(rsp_lin == VECS[i].lin, $sformatf("R6 linear vec %0d", i), rsp_lin, VECS[i].lin);
        end

        // R6 idle cycle
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 no response without request", {31'd0, rsp_valid}, 32'd0);

        // R10 slot difference on writable data executed
        do_load(1'b1, 32'h0, 32'hFFFF, 32'h920000);
        do_req(32'h10, 2'd2, 2'd0);
        check(rsp_fault == 1'b0, "R10 code slot executes writable data", {31'd0, rsp_fault}, 32'd0);
        check(ds_rsp_fault == 1'b1, "R10 other slot refuses execute on data", {31'd0, ds_rsp_fault}, 32'd1);

        // R11 size report
        do_load(1'b1, 32'h0, 32'hFFFF, 32'h922000);
        check(cs_op32 == 1'b1, "R11 code slot reports 32-bit", {31'd0, cs_op32}, 32'd1);
        check(ds_op32 == 1'b0, "R11 other slot reports 0", {31'd0, ds_op32}, 32'd0);
        do_load(1'b1, 32'h0, 32'hFFFF, 32'h920000);
        check(cs_op32 == 1'b0, "R11 code slot reports 16-bit", {31'd0, cs_op32}, 32'd0);

        // R4 refused ordinary load keeps old cache
        do_load(1'b1, 32'h0, 32'hFFF, 32'h920000);
        do_load(1'b0, 32'h0, 32'h0, 32'h120000);
        check(ld_done == 1'b1, "R4 refused load still acknowledged", {31'd0, ld_done}, 32'd1);
        check(ld_vec == 8'd11, "R4 refused load vector", {24'd0, ld_vec}, 32'd11);
        do_req(32'h800, 2'd0, 2'd0);
        check(rsp_fault == 1'b0, "R4 cache unchanged after refusal", {31'd0, rsp_fault}, 32'd0);

        // R5 direct absent load accepted, use faults
        do_load(1'b1, 32'h0, 32'hFFFF, 32'h120000);
        check(ld_vec == 8'd0, "R5 direct absent load accepted", {24'd0, ld_vec}, 32'd0);
        do_req(32'h0, 2'd0, 2'd0);
        check(rsp_fault == 1'b1 && rsp_vec == 8'd13, "R5 use of absent cache faults",
              {24'd0, rsp_vec}, 32'd13);
        do_req(32'h4, 2'd1, 2'd0);
        check(rsp_fault == 1'b1, "R5 second use still faults", {31'd0, rsp_fault}, 32'd1);

        // R14 load and request in the same cycle
        do_load(1'b1, 32'h0, 32'hFFF, 32'h920000);
        ld_valid = 1'b1; ld_direct = 1'b1; ld_base = 32'h0; ld_limit = 32'h0; ld_rights = 32'h920000;
        rq_valid = 1'b1; rq_offset = 32'h10; rq_kind = 2'd0; rq_cpl = 2'd0;
        @(negedge clk);
        ld_valid = 1'b0; rq_valid = 1'b0;
        check(rsp_fault == 1'b0, "R14 same-cycle request uses old limit", {31'd0, rsp_fault}, 32'd0);
        check(ld_vec == 8'd0 && ld_done == 1'b1, "R14 same-cycle load accepted", {24'd0, ld_vec}, 32'd0);
        do_req(32'h10, 2'd0, 2'd0);
        check(rsp_fault == 1'b1, "R14 next request uses new limit", {31'd0, rsp_fault}, 32'd1);

        // R2 ordinary load with granularity 0 keeps raw limit
        do_load(1'b0, 32'h0, 32'h20, 32'h920000);
        do_req(32'h21, 2'd0, 2'd0);
        check(rsp_fault == 1'b1, "R2 unscaled limit edge", {31'd0, rsp_fault}, 32'd1);

        finish_run();
    end
endmodule